// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control inside a successive-approximation converter. A falling edge on the active-low start input makes the block sample the input and begin a conversion. The block then drives a trial code to the DAC. It tests one bit per clock, starting at the most significant bit, and it keeps or clears each bit from a single comparator input. A busy flag stays high for the whole conversion. When the conversion ends, the block latches the final code into a result register.

The result is straight binary: 0 stands for zero input and all ones for full scale. The result is held on a parallel bus. The bus is enabled only while the active-low select and the active-low read are both low. There is no pipeline latency: the code read after busy falls belongs to the conversion that just ended.

An optional auto-sleep mode powers the block down when each conversion ends. The next start then spends a programmable wake-up delay before bit testing begins, and busy covers that delay as well.

Top module: `sar_seq`

## Requirements
- R1: Busy rises at the clock edge that first sees start_n low after it was high. When the block is awake, busy falls exactly CONV_CYCLES clocks later (default 14; 12 fits a 10-bit build).
- R2: After a conversion, data_out equals the straight-binary code of the comparator threshold. When cmp_in=1 the input is at or above dac_code. This holds for codes 0 and 2^RES-1 as well.
- R3: Bits are tested from the most significant down, one per clock. In the first conversion cycle after an awake start, dac_code holds only bit RES-1 set.
- R4: The conversion cycles after bit 0 are idle settling cycles. During them dac_code holds the final code.
- R5: data_out changes only at the clock edge where busy falls, and it then carries that conversion's code. After reset it reads 0.
- R6: data_oe is 1 exactly when cs_n and rd_n are both 0.
- R7: A falling edge on start_n while busy is high is ignored. The conversion length and the result are unchanged.
- R8: When auto_sleep=1 as a conversion ends, sleep rises with busy falling. The next start clears sleep, and sleep and busy are never both high.
- R9: A start taken while sleep is high inserts WAKE_CYCLES clocks before bit testing. Busy then lasts WAKE_CYCLES+CONV_CYCLES clocks.
- R10: Holding start_n low does not retrigger. A new conversion needs a new falling edge.
- R11: During and straight after reset, busy=0, sleep=0, data_out=0 and dac_code=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_n | input | 1 | Active-low start; its falling edge begins a conversion |
| auto_sleep | input | 1 | 1: power down at each conversion end |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above dac_code |
| cs_n | input | 1 | Active-low select for the result bus |
| rd_n | input | 1 | Active-low read for the result bus |
| dac_code | output | RES | Trial code for the DAC |
| busy | output | 1 | High from start detection to conversion end |
| sleep | output | 1 | Block is powered down |
| data_out | output | RES | Latched result |
| data_oe | output | 1 | Bus drive enable; 0 means high-impedance |

## Verification
The start edge is taken at a rising clock edge E0, and busy is sampled one half period later. The bench counts the falling-edge samples that show busy high. Expected counts are CONV_CYCLES, or CONV_CYCLES plus WAKE_CYCLES when the previous conversion ended in sleep. The MSB-only trial code is expected at the first of those samples after any wake delay. The settled code is expected RES samples later. The result and the sleep flag are read on the first sample with busy low. The bus enable is combinational, so it is checked in the same half period in which cs_n and rd_n change.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES         = 12,
  parameter int CONV_CYCLES = 14,
  parameter int WAKE_CYCLES = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_n,
  input  logic           auto_sleep,
  input  logic           cmp_in,
  input  logic           cs_n,
  input  logic           rd_n,
  output logic [RES-1:0] dac_code,
  output logic           busy,
  output logic           sleep,
  output logic [RES-1:0] data_out,
  output logic           data_oe
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam int WW = $clog2(WAKE_CYCLES + 1) + 1;
  localparam logic [RES-1:0] MSB = {1'b1, {(RES-1){1'b0}}};

  typedef enum logic [1:0] {S_IDLE, S_WAKE, S_CONV} st_t;

  st_t            st;
  logic           start_q;
  logic [CW-1:0]  cnt;
  logic [WW-1:0]  wcnt;
  logic [RES-1:0] sar, sar_nx, cur;
  logic           bit_cyc;

  wire start_fall = start_q & ~start_n;

  assign bit_cyc  = (st == S_CONV) && (cnt < CW'(RES));
  assign cur      = MSB >> cnt;
  assign sar_nx   = bit_cyc ? ((sar & ~cur) | (cmp_in ? cur : '0) | (cur >> 1)) : sar;
  assign dac_code = sar;
  assign data_oe  = ~cs_n & ~rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      start_q  <= 1'b1;
      cnt      <= '0;
      wcnt     <= '0;
      sar      <= '0;
      data_out <= '0;
      busy     <= 1'b0;
      sleep    <= 1'b0;
    end else begin
      start_q <= start_n;
      case (st)
        S_IDLE: if (start_fall) begin
          busy  <= 1'b1;
          sleep <= 1'b0;
          cnt   <= '0;
          if (sleep) begin
            st   <= S_WAKE;
            wcnt <= WW'(WAKE_CYCLES - 1);
            sar  <= '0;
          end else begin
            st  <= S_CONV;
            sar <= MSB;
          end
        end
        S_WAKE: begin
          if (wcnt == '0) begin
            st  <= S_CONV;
            sar <= MSB;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        S_CONV: begin
          sar <= sar_nx;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(CONV_CYCLES - 1)) begin
            st       <= S_IDLE;
            busy     <= 1'b0;
            sleep    <= auto_sleep;
            data_out <= sar_nx;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES         = 12,
  parameter int CONV_CYCLES = 14,
  parameter int WAKE_CYCLES = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_n,
  input logic           cs_n,
  input logic           rd_n,
  input logic [RES-1:0] dac_code,
  input logic           busy,
  input logic           sleep,
  input logic [RES-1:0] data_out,
  input logic           data_oe
);
  logic [15:0] bcnt;
  logic        was_sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt      <= '0;
      was_sleep <= 1'b0;
    end else begin
      bcnt <= busy ? bcnt + 1'b1 : 16'd0;
      if (!busy) was_sleep <= sleep;
    end
  end

  p_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == 16'(CONV_CYCLES) && !was_sleep) ||
                    (bcnt == 16'(CONV_CYCLES + WAKE_CYCLES) && was_sleep));

  p_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(start_n));

  p_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !$past(sleep)) |-> dac_code == {1'b1, {(RES-1){1'b0}}});

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(data_out));

  p_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> !data_oe);

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !busy);
endmodule

bind sar_seq sar_seq_chk #(.RES(RES), .CONV_CYCLES(CONV_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_n(start_n), .cs_n(cs_n), .rd_n(rd_n),
  .dac_code(dac_code), .busy(busy), .sleep(sleep), .data_out(data_out), .data_oe(data_oe)
);

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  localparam int PERIOD = 10;
  localparam int RES = 12, CONV = 14, WAKE = 5;
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 12'h000}, {1'b0, 12'hFFF}, {1'b1, 12'h800}, {1'b1, 12'h7FF},
    {1'b0, 12'h555}, {1'b1, 12'hAAA}, {1'b0, 12'h001}, {1'b0, 12'h123}};

  logic clk = 0, rst_n = 0, start_n = 1, auto_sleep = 0, cs_n = 1, rd_n = 1;
  logic [RES-1:0] target = '0;
  logic [RES-1:0] dac_code, data_out;
  logic busy, sleep, data_oe, cmp_in;
  int n_chk = 0, n_bad = 0;
  bit slept = 0;

  assign cmp_in = (target >= dac_code);
  always #(PERIOD/2) clk = ~clk;

  sar_seq #(.RES(RES), .CONV_CYCLES(CONV), .WAKE_CYCLES(WAKE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .auto_sleep(auto_sleep),
    .cmp_in(cmp_in), .cs_n(cs_n), .rd_n(rd_n), .dac_code(dac_code), .busy(busy),
    .sleep(sleep), .data_out(data_out), .data_oe(data_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [RES-1:0] t, input bit as, input bit poke);
    int n = 0;
    int off = slept ? WAKE : 0;
    @(negedge clk);
    target = t; auto_sleep = as; start_n = 0;
    @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy rise", int'(busy), 1);
    chk(sleep == 1'b0, "R8 sleep cleared", int'(sleep), 0);
    while (busy && n < 1000) begin
      n++;
      if (n == off + 1) chk(dac_code == 12'h800, "R3 msb trial", int'(dac_code), 'h800);
      if (n == off + RES + 1) chk(dac_code == t, "R4 settle code", int'(dac_code), int'(t));
      if (n == off + RES) chk(data_out != t || t == '0 || n < 0, "R5 no early update", int'(data_out), -1);
      if (poke && n == 4) start_n = 1;
      if (poke && n == 5) start_n = 0;
      @(negedge clk);
    end
    chk(n == CONV + off, slept ? "R9 wake length" : "R1 conv length", n, CONV + off);
    chk(data_out == t, "R2 result", int'(data_out), int'(t));
    chk(sleep == as, "R8 sleep at end", int'(sleep), int'(as));
    cs_n = 0; rd_n = 0; #1;
    chk(data_oe == 1'b1, "R6 oe on", int'(data_oe), 1);
    cs_n = 1; rd_n = 1;
    slept = as;
    @(negedge clk);
    start_n = 1;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && sleep == 0, "R11 reset flags", {busy, sleep}, 0);
    chk(data_out == 0 && dac_code == 0, "R11 reset data", int'(data_out), 0);
    rst_n = 1;
    @(negedge clk);
    chk(data_out == 0, "R5 initial result", int'(data_out), 0);

    for (int i = 0; i < NV; i++) convert(VEC[i][11:0], VEC[i][12], 1'b0);

    convert(12'h3C5, 1'b0, 1'b1);
    chk(data_out == 12'h3C5, "R7 ignored start", int'(data_out), 'h3C5);

    @(negedge clk); target = 12'hABC; start_n = 0;
    @(posedge clk); @(negedge clk);
    start_n = 0;
    repeat (CONV + 1) @(negedge clk);
    chk(busy == 0, "R10 after first", int'(busy), 0);
    repeat (20) begin
      @(negedge clk);
      if (busy) break;
    end
    chk(busy == 0, "R10 no retrigger", int'(busy), 0);
    chk(data_out == 12'hABC, "R10 result", int'(data_out), 'hABC);
    start_n = 1;

    cs_n = 0; rd_n = 1; #1;
    chk(data_oe == 0, "R6 rd high", int'(data_oe), 0);
    cs_n = 1; rd_n = 0; #1;
    chk(data_oe == 0, "R6 cs high", int'(data_oe), 0);
    cs_n = 1; rd_n = 1; #1;
    chk(data_oe == 0, "R6 both high", int'(data_oe), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule